// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches every pin of a GPIO port and raises a single port interrupt when a configured pin event occurs. Each pin arrives asynchronously and passes through a synchronizer chain. A per-pin event detector then looks for either a level or an edge, depending on three configuration bits for that pin: a mode bit, a polarity bit and a both-edges bit. A detected event sets a sticky per-pin flag. The flags are gated by a per-pin enable and then ORed into `irq_o`.

Software reaches the block through a small word-addressed register bus. Writes take effect on the clock edge. Reads are combinational from the address. The enable register can be written directly, or changed bit by bit through set and clear aliases. The flag register is read-only and has its own clear alias, which removes only the bits written as 1.

One detail of the polarity bit is easy to get wrong. In level mode, polarity 0 means active-high. In edge mode, polarity 0 means falling edge.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every register reads zero: MODE (addr 0), POL (1), BOTH (2), IEN (3), FLAG (6) and PIN (8). In addition, `irq_o` is low, and the write-only aliases (4, 5, 7) read zero.
- R2: Level mode is MODE bit 0. With POL bit 0, the pin's flag is set on every cycle that its synchronized value is high. Clearing the flag while the level persists leaves it set.
- R3: With MODE bit 0 and POL bit 1, the flag is set on every cycle that the synchronized pin is low.
- R4: Edge mode is MODE bit 1. With MODE bit 1, BOTH bit 0 and POL bit 0, only a falling edge sets the flag, and a rising edge does not.
- R5: With MODE bit 1, BOTH bit 0 and POL bit 1, only a rising edge sets the flag, and a falling edge does not.
- R6: With MODE bit 1 and BOTH bit 1, both edges set the flag, whatever POL holds. With MODE bit 0, the BOTH bit has no effect.
- R7: Writes to address 3 load IEN. Writes to address 4 set the IEN bits written as 1. Writes to address 5 clear the IEN bits written as 1. All other IEN bits keep their value.
- R8: A write to address 7 clears only the FLAG bits written as 1. A new event on a bit in the same cycle as its clear leaves that bit set. Writes to address 6 change nothing.
- R9: `irq_o` is high exactly when some pin has both its flag and its enable set. Flags are set whether or not the pin is enabled.
- R10: With two synchronizer stages, a pin change shows in PIN (address 8) after the second rising edge that samples it. The resulting flag shows after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | PINS | Asynchronous pin levels |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | AW | Word address of the register access |
| reg_wdata | input | PINS | Write data |
| reg_rdata | output | PINS | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Port interrupt, OR of enabled flags |

## Verification
The assertions assume that `reg_we` is a one-cycle strobe whose address and data are valid in the same cycle. They also assume that a pin event comes only from the synchronized input and the previous synchronized value, never from bus activity. The stimulus drives pins and bus signals shortly after each rising edge. As a result, every sampling edge sees settled values and each write lands in exactly one cycle. The random phase mixes pin toggles with writes to every address, including the read-only ones. This lets clear-versus-event collisions and enable changes occur under all mode and polarity combinations, while the reference model is compared on every clock.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_i,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [PINS-1:0] reg_wdata,
  output logic [PINS-1:0] reg_rdata,
  output logic            irq_o
);

  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_POL  = AW'(1);
  localparam logic [AW-1:0] A_BOTH = AW'(2);
  localparam logic [AW-1:0] A_IEN  = AW'(3);
  localparam logic [AW-1:0] A_ISET = AW'(4);
  localparam logic [AW-1:0] A_ICLR = AW'(5);
  localparam logic [AW-1:0] A_FLAG = AW'(6);
  localparam logic [AW-1:0] A_FCLR = AW'(7);
  localparam logic [AW-1:0] A_PIN  = AW'(8);

  logic [PINS-1:0] sync_q [SYNC_STAGES];
  logic [PINS-1:0] pin_s, prev_q, ev;
  logic [PINS-1:0] mode_q, pol_q, both_q, ien_q, flag_q;
  logic wr_mode, wr_pol, wr_both, wr_ien, wr_iset, wr_iclr, wr_fclr;

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= pin_s;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_det
    logic rise, fall;
    assign rise = pin_s[i] & ~prev_q[i];
    assign fall = ~pin_s[i] & prev_q[i];
    assign ev[i] = !mode_q[i] ? (pin_s[i] ^ pol_q[i]) :
                   both_q[i]  ? (rise | fall) :
                   pol_q[i]   ? rise : fall;
  end

  assign wr_mode = reg_we && (reg_addr == A_MODE);
  assign wr_pol  = reg_we && (reg_addr == A_POL);
  assign wr_both = reg_we && (reg_addr == A_BOTH);
  assign wr_ien  = reg_we && (reg_addr == A_IEN);
  assign wr_iset = reg_we && (reg_addr == A_ISET);
  assign wr_iclr = reg_we && (reg_addr == A_ICLR);
  assign wr_fclr = reg_we && (reg_addr == A_FCLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= '0;
      both_q <= '0;
      ien_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata;
      if (wr_pol)  pol_q  <= reg_wdata;
      if (wr_both) both_q <= reg_wdata;
      if (wr_ien)       ien_q <= reg_wdata;
      else if (wr_iset) ien_q <= ien_q | reg_wdata;
      else if (wr_iclr) ien_q <= ien_q & ~reg_wdata;
      flag_q <= (flag_q & ~(wr_fclr ? reg_wdata : '0)) | ev;
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = mode_q;
      A_POL:   reg_rdata = pol_q;
      A_BOTH:  reg_rdata = both_q;
      A_IEN:   reg_rdata = ien_q;
      A_FLAG:  reg_rdata = flag_q;
      A_PIN:   reg_rdata = pin_s;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o = |(flag_q & ien_q);

  p_event_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((flag_q & $past(ev)) == $past(ev)));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fclr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  p_clear_removes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fclr |=> ((flag_q & $past(reg_wdata & ~ev)) == '0));

  p_ien_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_iset |=> ((ien_q & $past(reg_wdata)) == $past(reg_wdata)));

  p_ien_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_iclr |=> ((ien_q & $past(reg_wdata)) == '0));

  p_ien_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ien || wr_iset || wr_iclr) |=> $stable(ien_q));

endmodule

// File: tb/gpio_irq_detect_tb_top.sv
module gpio_irq_detect_tb_top;
  localparam int P = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [P-1:0] pin_i = '0;
  logic         reg_we = 1'b0;
  logic [3:0]   reg_addr = 4'd6;
  logic [P-1:0] reg_wdata = '0;
  logic [P-1:0] reg_rdata;
  logic         irq_o;

  always #5 clk = ~clk;

  gpio_irq_detect #(.PINS(P), .SYNC_STAGES(2), .AW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference model
  logic [P-1:0] m_mode, m_pol, m_both, m_ien, m_flag, m_prev;
  logic [P-1:0] m_q[$];

  function automatic logic [P-1:0] m_events();
    logic [P-1:0] e;
    for (int i = 0; i < P; i++) begin
      bit s = m_q[0][i];
      bit p = m_prev[i];
      bit rise = s && !p;
      bit fall = !s && p;
      if (!m_mode[i]) e[i] = m_pol[i] ? !s : s;
      else if (m_both[i]) e[i] = rise || fall;
      else e[i] = m_pol[i] ? rise : fall;
    end
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = '0; m_pol = '0; m_both = '0; m_ien = '0; m_flag = '0; m_prev = '0;
      m_q = {};
      m_q.push_back('0);
      m_q.push_back('0);
    end else begin
      logic [P-1:0] e;
      e = m_events();
      if (reg_we && reg_addr == 4'd7) m_flag = m_flag & ~reg_wdata;
      m_flag = m_flag | e;
      if (reg_we) begin
        case (reg_addr)
          4'd0: m_mode = reg_wdata;
          4'd1: m_pol  = reg_wdata;
          4'd2: m_both = reg_wdata;
          4'd3: m_ien  = reg_wdata;
          4'd4: m_ien  = m_ien | reg_wdata;
          4'd5: m_ien  = m_ien & ~reg_wdata;
          default: ;
        endcase
      end
      m_prev = m_q[0];
      void'(m_q.pop_front());
      m_q.push_back(pin_i);
    end
  end

  task automatic chk(input string req, input logic [P-1:0] got, input logic [P-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " irq"}, {31'b0, irq_o}, {31'b0, |(m_flag & m_ien)});
      if (!reg_we && reg_addr == 4'd6) chk({cur_req, " flag"}, reg_rdata, m_flag);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [3:0] a, input logic [P-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_addr = 4'd6; reg_wdata = '0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [P-1:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
    reg_addr = 4'd6;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1: reset values
    for (int a = 0; a < 9; a++) rd("R1 reset reg", 4'(a), '0);
    chk("R1 reset irq", {31'b0, irq_o}, '0);
    rst_n = 1'b1;
    step(2);

    // R7: set alias enables everything
    cur_req = "R7";
    wr(4'd4, '1);
    rd("R7 set alias", 4'd3, '1);

    // R2 / R10: level high, latency
    cur_req = "R2";
    pin_i[1] = 1'b1;
    step(2);
    rd("R10 pin after two edges", 4'd8, 32'h2);
    rd("R10 flag not yet", 4'd6, '0);
    step();
    rd("R10 flag after third edge", 4'd6, 32'h2);
    chk("R9 irq with enabled flag", {31'b0, irq_o}, 32'h1);
    wr(4'd7, 32'h2);
    rd("R2 clear while level held", 4'd6, 32'h2);
    pin_i[1] = 1'b0;
    step(3);
    wr(4'd7, 32'h2);
    rd("R2 clear after level gone", 4'd6, '0);

    // R3: active-low level
    cur_req = "R3";
    wr(4'd1, 32'h4);
    step(2);
    rd("R3 low level flags", 4'd6, 32'h4);
    pin_i[2] = 1'b1;
    step(4);
    wr(4'd7, 32'h4);
    rd("R3 high level no flag", 4'd6, '0);

    // R4: falling edge only
    cur_req = "R4";
    wr(4'd0, 32'h10);
    pin_i[4] = 1'b1;
    step(4);
    rd("R4 rise ignored", 4'd6, '0);
    pin_i[4] = 1'b0;
    step(4);
    rd("R4 fall sets", 4'd6, 32'h10);
    wr(4'd7, 32'h10);

    // R5: rising edge only
    cur_req = "R5";
    wr(4'd1, 32'h24);
    wr(4'd0, 32'h30);
    pin_i[5] = 1'b1;
    step(4);
    rd("R5 rise sets", 4'd6, 32'h20);
    wr(4'd7, 32'h20);
    pin_i[5] = 1'b0;
    step(4);
    rd("R5 fall ignored", 4'd6, '0);

    // R6: both edges, polarity ignored; BOTH ignored in level mode
    cur_req = "R6";
    wr(4'd1, 32'h64);
    wr(4'd2, 32'hC0);
    wr(4'd0, 32'h70);
    pin_i[6] = 1'b1;
    step(4);
    rd("R6 rise sets", 4'd6, 32'h40);
    wr(4'd7, 32'h40);
    pin_i[6] = 1'b0;
    step(4);
    rd("R6 fall sets", 4'd6, 32'h40);
    wr(4'd7, 32'h40);
    pin_i[7] = 1'b1;
    step(4);
    rd("R6 level mode ignores BOTH", 4'd6, 32'h80);
    pin_i[7] = 1'b0;
    step(3);
    wr(4'd7, 32'h80);

    // R7: aliases touch only written ones
    cur_req = "R7";
    wr(4'd5, 32'h1);
    rd("R7 clear alias", 4'd3, 32'hFFFF_FFFE);
    wr(4'd3, 32'h10);
    wr(4'd4, 32'h20);
    rd("R7 set keeps others", 4'd3, 32'h30);
    wr(4'd5, 32'h10);
    rd("R7 clear keeps others", 4'd3, 32'h20);

    // R9: disabled flags set but stay masked
    cur_req = "R9";
    pin_i[1] = 1'b1;
    step(4);
    rd("R9 flag while disabled", 4'd6, 32'h2);
    chk("R9 irq masked", {31'b0, irq_o}, '0);
    wr(4'd4, 32'h2);
    chk("R9 irq once enabled", {31'b0, irq_o}, 32'h1);
    pin_i[1] = 1'b0;
    step(3);

    // R8: event beats clear in the same cycle; flag reg not writable
    cur_req = "R8";
    wr(4'd7, '1);
    pin_i[5] = 1'b1;
    step(2);
    wr(4'd7, 32'h20);
    rd("R8 event wins over clear", 4'd6, 32'h20);
    wr(4'd6, '1);
    rd("R8 flag write ignored", 4'd6, 32'h20);
    wr(4'd7, 32'h0);
    rd("R8 zero clear no effect", 4'd6, 32'h20);

    // random mix, checked against the model every clock
    cur_req = "R2-random";
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 9);
      if (r < 4) pin_i = pin_i ^ (32'h1 << $urandom_range(0, 31));
      if (r >= 7) begin
        int a = $urandom_range(0, 8);
        wr(4'(a), $urandom());
      end else step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule